// File: doc/BRIEF.md
# Multi-Channel Split Event Accumulator

The block keeps a running event total for each of several channels. A channel's total is split in two parts. The low-order part is a small counter that sits next to the channel and takes that channel's increment on every clock. The high-order part is kept, for all channels together, in one word-wide bank that can map onto block RAM. When a low counter wraps, the wrap is recorded as a sticky pending flag. A round-robin scanner picks the next pending channel. One shared byte-serial adder then reads that channel's high word, adds one starting at the least significant byte, stops at the first byte that does not carry, writes the word back and clears the flag. This avoids a full-width adder per channel that would run on every clock.

Each channel is either narrow or wide. A narrow channel counts single events and uses only bit 0 of its increment field. A wide channel adds an unsigned value of up to 31 per clock. Software reads the total of any channel on a simple request port. The returned value is always a consistent snapshot: if that channel's carry is still waiting for the serial adder, one is added to the high part on the read path. Totals start at zero after reset, count modulo 2^TOT_W and are never cleared.

Top module: `event_accum`

## Requirements
- R1: After reset, a read of any channel returns zero and every bit of `ovf` is 0.
- R2: A wide channel (its bit in NARROW_MASK is 0) adds the unsigned value of its 5-bit increment field, 0 to 31, on every rising clock edge.
- R3: A narrow channel (its bit in NARROW_MASK is 1) adds only bit 0 of its increment field. Bits 4..1 of that field have no effect on the total.
- R4: A read request sampled at clock edge k sets `rd_valid` high at edge k+1 for exactly one cycle. `rd_valid` is low after edge k.
- R5: The returned value is exact even when the channel's low counter has just wrapped and its carry has not yet been written into the high bank.
- R6: The returned value equals the low TOT_W bits of the sum of the effective increments sampled on edges before edge k. This covers carries that ripple across several bytes of the high word and the wrap of the whole total.
- R7: The overflow bit `ovf[c]` is set only when channel c wraps again while its previous carry is still pending. It stays 0 as long as no channel wraps more often than once every NCH*(ceil(HI_W/8)+3) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_flat | input | NCH*INC_W | Per-channel increment fields; channel c occupies bits c*INC_W upward |
| rd_en | input | 1 | Read request, one cycle per request |
| rd_ch | input | CH_W | Channel selected by the read |
| rd_valid | output | 1 | One-cycle strobe marking rd_data valid |
| rd_data | output | TOT_W | Total of the selected channel, high part over low part |
| ovf | output | NCH | Sticky per-channel overflow flags |

## Verification
The increments driven in one cycle enter the bench's model at the edge that samples them. A read's expected value is taken from the model before the increments of the request cycle are added, because the design snapshots the total on that same edge. The result is due one edge after the sampling edge. The bench therefore samples `rd_valid` low after the request edge and high, with the data, after the next edge, always at a falling edge. Further reads are placed right after a wide channel's low counter wraps, so that the pending carry is still in flight when the snapshot is taken. A long run at the maximum rate drives the high word through multi-byte ripples and a full modulo wrap.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ADD  = 2'd2,
    ST_WR   = 2'd3
  } add_state_t;
endpackage

// File: rtl/acc_lo_counter.sv
module acc_lo_counter #(
  parameter int LO_W   = 16,
  parameter int INC_W  = 5,
  parameter bit NARROW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  output logic [LO_W-1:0]  lo_q,
  output logic             wrap
);
  logic [INC_W-1:0] eff;
  logic [LO_W:0]    sum;

  generate
    if (NARROW) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^inc[INC_W-1:1];
      assign eff = {{(INC_W-1){1'b0}}, inc[0]};
    end else begin : g_wide
      assign eff = inc;
    end
  endgenerate

  always_comb begin
    sum  = {1'b0, lo_q} + (LO_W+1)'(eff);
    wrap = sum[LO_W];
  end

  always_ff @(posedge clk) begin
    if (rst) lo_q <= '0;
    else     lo_q <= sum[LO_W-1:0];
  end

  generate
    if (NARROW) begin : g_chk
      AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (lo_q == {LO_W{1'b1}}));  // R3
    end
  endgenerate
endmodule

// File: rtl/acc_carry_scan.sv
module acc_carry_scan #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  wrap,
  input  logic            take,
  input  logic            clr_en,
  input  logic [CH_W-1:0] clr_ch,
  output logic [NCH-1:0]  pend,
  output logic [NCH-1:0]  ovf,
  output logic            gnt_v,
  output logic [CH_W-1:0] gnt_ch
);
  logic [CH_W-1:0] rr;
  logic [NCH-1:0]  clr;

  always_comb begin
    for (int c = 0; c < NCH; c++) clr[c] = clr_en && (clr_ch == CH_W'(c));
  end

  always_comb begin
    gnt_v  = 1'b0;
    gnt_ch = '0;
    for (int i = 0; i < NCH; i++) begin
      int idx;
      idx = (int'(rr) + i) % NCH;
      if (!gnt_v && pend[idx]) begin
        gnt_v  = 1'b1;
        gnt_ch = CH_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ovf  <= '0;
      rr   <= '0;
    end else begin
      pend <= (pend & ~clr) | wrap;
      ovf  <= ovf | (wrap & pend & ~clr);
      if (take) rr <= (gnt_ch == CH_W'(NCH-1)) ? '0 : gnt_ch + 1'b1;
    end
  end

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    take |-> pend[gnt_ch]);  // R5
  AST_CLEAR_PENDING: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> pend[clr_ch]);  // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wrap & pend & ~clr) == '0);  // R7
endmodule

// File: rtl/acc_hi_bank.sv
module acc_hi_bank #(
  parameter int NCH  = 8,
  parameter int CH_W = 3,
  parameter int HI_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] a_addr,
  input  logic            a_we,
  input  logic [HI_W-1:0] a_wdata,
  output logic [HI_W-1:0] a_rdata,
  input  logic [CH_W-1:0] b_addr,
  output logic [HI_W-1:0] b_rdata
);
  logic [HI_W-1:0] mem [NCH];
  logic [HI_W-1:0] qa, qb;
  logic [NCH-1:0]  written;
  logic            va, vb;

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    qa <= mem[a_addr];
    qb <= mem[b_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      va      <= 1'b0;
      vb      <= 1'b0;
    end else begin
      if (a_we) written[a_addr] <= 1'b1;
      va <= written[a_addr];
      vb <= written[b_addr];
    end
  end

  assign a_rdata = va ? qa : '0;
  assign b_rdata = vb ? qb : '0;
endmodule

// File: rtl/acc_serial_adder.sv
module acc_serial_adder
  import acc_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int HI_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gnt_v,
  input  logic [CH_W-1:0] gnt_ch,
  output logic            take,
  output logic [CH_W-1:0] a_addr,
  output logic            a_we,
  output logic [HI_W-1:0] a_wdata,
  input  logic [HI_W-1:0] a_rdata,
  output logic            clr_en,
  output logic [CH_W-1:0] clr_ch
);
  localparam int NB   = (HI_W + 7) / 8;
  localparam int BI_W = (NB > 1) ? $clog2(NB) : 1;

  add_state_t      st;
  logic [CH_W-1:0] cur;
  logic [NB*8-1:0] word;
  logic [BI_W-1:0] bi;
  logic [8:0]      bsum;

  assign take    = (st == ST_IDLE) && gnt_v;
  assign a_addr  = (st == ST_IDLE) ? gnt_ch : cur;
  assign a_we    = (st == ST_WR);
  assign a_wdata = word[HI_W-1:0];
  assign clr_en  = (st == ST_WR);
  assign clr_ch  = cur;

  always_comb bsum = {1'b0, word[int'(bi)*8 +: 8]} + 9'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cur  <= '0;
      word <= '0;
      bi   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (gnt_v) begin
          cur <= gnt_ch;
          st  <= ST_LOAD;
        end
        ST_LOAD: begin
          word <= (NB*8)'(a_rdata);
          bi   <= '0;
          st   <= ST_ADD;
        end
        ST_ADD: begin
          word[int'(bi)*8 +: 8] <= bsum[7:0];
          if (!bsum[8] || bi == BI_W'(NB-1)) st <= ST_WR;
          else                               bi <= bi + 1'b1;
        end
        ST_WR: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WRITE_AFTER_ADD: assert property (@(posedge clk) disable iff (rst)
    a_we |-> $past(st) == ST_ADD);  // R6
  AST_CUR_HELD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(cur));  // R6
endmodule

// File: rtl/event_accum.sv
module event_accum #(
  parameter int          NCH         = 8,
  parameter int          LO_W        = 16,
  parameter int          TOT_W       = 48,
  parameter int          INC_W       = 5,
  parameter logic [63:0] NARROW_MASK = 64'h5555_5555_5555_5555,
  localparam int         CH_W        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH*INC_W-1:0] inc_flat,
  input  logic               rd_en,
  input  logic [CH_W-1:0]    rd_ch,
  output logic               rd_valid,
  output logic [TOT_W-1:0]   rd_data,
  output logic [NCH-1:0]     ovf
);
  localparam int HI_W = TOT_W - LO_W;

  logic [LO_W-1:0] lo_all [NCH];
  logic [NCH-1:0]  wrap, pend;
  logic            gnt_v, take, a_we, clr_en;
  logic [CH_W-1:0] gnt_ch, a_addr, clr_ch;
  logic [HI_W-1:0] a_wdata, a_rdata, b_rdata;

  logic            s1_v, s1_p;
  logic [LO_W-1:0] s1_lo;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      acc_lo_counter #(
        .LO_W(LO_W), .INC_W(INC_W), .NARROW(NARROW_MASK[c])
      ) u_lo (
        .clk(clk), .rst(rst), .inc(inc_flat[c*INC_W +: INC_W]),
        .lo_q(lo_all[c]), .wrap(wrap[c])
      );
    end
  endgenerate

  acc_carry_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan (
    .clk(clk), .rst(rst), .wrap(wrap), .take(take),
    .clr_en(clr_en), .clr_ch(clr_ch), .pend(pend), .ovf(ovf),
    .gnt_v(gnt_v), .gnt_ch(gnt_ch)
  );

  acc_serial_adder #(.CH_W(CH_W), .HI_W(HI_W)) u_add (
    .clk(clk), .rst(rst), .gnt_v(gnt_v), .gnt_ch(gnt_ch), .take(take),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .clr_en(clr_en), .clr_ch(clr_ch)
  );

  acc_hi_bank #(.NCH(NCH), .CH_W(CH_W), .HI_W(HI_W)) u_bank (
    .clk(clk), .rst(rst), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .b_addr(rd_ch), .b_rdata(b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_p     <= 1'b0;
      s1_lo    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      s1_v     <= rd_en;
      s1_p     <= pend[rd_ch];
      s1_lo    <= lo_all[rd_ch];
      rd_valid <= s1_v;
      if (s1_v) rd_data <= {b_rdata + HI_W'(s1_p), s1_lo};
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) |=> rd_valid);  // R4
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !s1_v) |=> !rd_valid);  // R4
endmodule

// File: tb/sim_event_accum.sv
module sim_event_accum;
  localparam int          NCH   = 4;
  localparam int          LO_W  = 10;
  localparam int          TOT_W = 21;
  localparam int          INC_W = 5;
  localparam logic [63:0] NMASK = 64'h5;
  localparam int          CH_W  = 2;
  localparam longint      TMASK = (64'sd1 <<< TOT_W) - 1;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NCH*INC_W-1:0]   inc_flat = '0;
  logic                   rd_en = 1'b0;
  logic [CH_W-1:0]        rd_ch = '0;
  logic                   rd_valid;
  logic [TOT_W-1:0]       rd_data;
  logic [NCH-1:0]         ovf;

  int     n_chk = 0;
  int     n_bad = 0;
  int     mode  = 0;
  int     cyc   = 0;
  longint tot [NCH];

  always #2 clk = ~clk;

  event_accum #(
    .NCH(NCH), .LO_W(LO_W), .TOT_W(TOT_W), .INC_W(INC_W), .NARROW_MASK(NMASK)
  ) u0 (
    .clk(clk), .rst(rst), .inc_flat(inc_flat), .rd_en(rd_en), .rd_ch(rd_ch),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gen(input int c);
    case (mode)
      1:       return 31;
      2:       return (c * 11 + cyc * 7 + (cyc >> 3)) % 32;
      default: return 0;
    endcase
  endfunction

  task automatic tick(input logic rd, input int ch);
    int raw [NCH];
    for (int c = 0; c < NCH; c++) begin
      raw[c] = gen(c);
      inc_flat[c*INC_W +: INC_W] = INC_W'(raw[c]);
    end
    rd_en = rd;
    rd_ch = CH_W'(ch);
    @(posedge clk);
    for (int c = 0; c < NCH; c++)
      tot[c] += NMASK[c] ? longint'(raw[c] & 1) : longint'(raw[c]);
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_read(input int ch, input string req);
    longint e;
    e = tot[ch] & TMASK;
    tick(1'b1, ch);
    check("R4", longint'(rd_valid), 0);
    tick(1'b0, 0);
    check("R4", longint'(rd_valid), 1);
    check(req, longint'(rd_data), e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) tot[c] = 0;
    @(negedge clk);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: zero after reset
    for (int c = 0; c < NCH; c++) do_read(c, "R1");
    check("R1", longint'(ovf), 0);

    // R2 / R3: mixed increments, narrow channels see garbage upper bits
    mode = 2;
    for (int n = 0; n < 110; n++) begin
      repeat (27) tick(1'b0, 0);
      do_read(n % NCH, NMASK[n % NCH] ? "R3" : "R2");
    end

    // R5: read right after a wide channel wraps
    mode = 1;
    for (int n = 0; n < 8; n++) begin
      int ch;
      ch = (n % 2) ? 3 : 1;
      tick(1'b0, 0);
      while ((tot[ch] % 1024) >= 31) tick(1'b0, 0);
      do_read(ch, "R5");
    end

    // R6: long run at maximum rate, multi-byte ripple and full wrap
    for (int n = 0; n < 276; n++) begin
      repeat (249) tick(1'b0, 0);
      do_read(n % NCH, "R6");
    end
    check("R6", longint'(tot[1] > TMASK), 1);

    // R7: no overflow under the rate limit
    check("R7", longint'(ovf), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule